// File: doc/BRIEF.md
# Averaged Period Meter

The block measures the period of a squared-up signal coming from a vibrating source. It counts system clock cycles across a window of NPER whole input periods, with NPER = 32 by default. The window runs from one rising edge of the synchronized input to the rising edge NPER periods later. One long count gives the same averaged figure as summing NPER single-period counts, but it needs a single accumulator instead of NPER stored values. With a 50 MHz clock, one period of a low note needs up to CNT_W = 21 bits, so the accumulator is CNT_W + log2(NPER) = 26 bits wide.

A start pulse does four things: it samples a setpoint and a timeout limit, clears the previous result and arms the meter. When the window closes, the block presents the accumulated count and a signed error (count minus setpoint), and pulses a one-cycle done strobe. If the input stops toggling, a programmable timeout abandons the measurement and raises a flag. The host issues start, waits for done or the timeout flag, and reads the count and the error.

Top module: `period_avg_meter`

## Requirements
- R1: While reset is held and after it is released, count_o, err_o, done_o and tmo_o are all zero.
- R2: count_o equals the number of clock cycles between the first rising edge of the synchronized sig_i seen after start and the rising edge NPER periods later. That is the sum of NPER consecutive input periods measured in clocks.
- R3: err_o is the 27-bit two's-complement value count_o minus the setpoint. It is negative when the count is below the setpoint and zero when the two are equal.
- R4: done_o is high for exactly one clock, in the same cycle that count_o and err_o take their new values.
- R5: count_o and err_o keep their values until the next start, and input edges after completion do not change them. A start clears count_o, err_o and tmo_o in the cycle that follows it.
- R6: A start issued during a measurement discards the partial window and begins a new one from the next rising edge.
- R7: The timeout limit applies while the meter is armed or measuring. An interval between rising edges of at most the limit is accepted. When limit clocks pass after the last edge (or after start) with no new edge, the measurement is aborted: tmo_o is set, done_o does not pulse and count_o stays zero.
- R8: Only rising edges bound the periods. The high time and low time of each period, taken separately, have no effect on count_o.
- R9: setpoint_i and tmo_limit_i are sampled at start. Changing them during a measurement has no effect on err_o or on the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sig_i | input | 1 | Asynchronous squared input whose period is measured |
| start_i | input | 1 | One-cycle pulse: sample settings, clear results, arm |
| setpoint_i | input | ACC_W (26) | Target count for the whole window |
| tmo_limit_i | input | TMO_W (21) | Longest accepted gap between rising edges, in clocks |
| count_o | output | ACC_W (26) | Clocks counted across NPER periods |
| err_o | output | ACC_W+1 (27) | count_o minus setpoint, two's complement |
| done_o | output | 1 | One-cycle strobe marking a valid result |
| tmo_o | output | 1 | Measurement abandoned for lack of input edges |

## Verification
The bench randomizes the high and low time of every period independently. A design that counted from a falling edge, or that counted only the high time, would then miss the expected sum. It sets the timeout limit exactly equal to the input period and then one clock below it. An off-by-one in the gap counter shows up as a timeout in the first case or a completed result in the second. It restarts mid-window and changes the setpoint mid-window: a design that kept the partial count would report too large a total, and one that read the setpoint live would report the wrong error. Setpoints far above the count check that the error keeps its sign across the full 27-bit width.

// File: rtl/pm_pkg.sv
package pm_pkg;
   typedef enum logic [1:0] {
      PM_IDLE = 2'd0,
      PM_ARM  = 2'd1,
      PM_RUN  = 2'd2
   } pm_state_t;
endpackage

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
   parameter int STAGES    = 2,
   parameter bit RISE_EDGE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic async_i,
   output logic edge_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   generate
      if (RISE_EDGE) begin : g_rise
         assign edge_o = chain_q[STAGES-1] & ~last_q;
      end else begin : g_fall
         assign edge_o = ~chain_q[STAGES-1] & last_q;
      end
   endgenerate
endmodule

// File: rtl/pm_watchdog.sv
module pm_watchdog #(
   parameter int TMO_W = 21
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             clear_i,
   input  logic             active_i,
   input  logic             edge_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             expire_o
);
   logic [TMO_W-1:0] gap_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || clear_i || !active_i) begin
         gap_q <= '0;
      end else if (edge_i) begin
         gap_q <= '0;
      end else begin
         gap_q <= gap_q + 1'b1;
      end
   end

   // Expiry wins over an edge arriving in the same cycle.
   assign expire_o = active_i && (gap_q == limit_i);
endmodule

// File: rtl/pm_window.sv
module pm_window #(
   parameter int ACC_W = 26,
   parameter int NPER  = 32,
   localparam int PER_W = $clog2(NPER)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             clear_i,
   input  logic             run_i,
   input  logic             edge_i,
   output logic [ACC_W-1:0] total_o,
   output logic             last_o
);
   logic [ACC_W-1:0] acc_q;
   logic [PER_W-1:0] per_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || clear_i) begin
         acc_q <= '0;
         per_q <= '0;
      end else if (run_i) begin
         acc_q <= acc_q + 1'b1;
         if (edge_i) begin
            per_q <= per_q + 1'b1;
         end
      end
   end

   // Count including the closing cycle.
   assign total_o = acc_q + 1'b1;
   assign last_o  = run_i && edge_i && (per_q == PER_W'(NPER - 1));
endmodule

// File: rtl/period_avg_meter.sv
module period_avg_meter
   import pm_pkg::*;
#(
   parameter int CNT_W       = 21,
   parameter int NPER        = 32,
   parameter int TMO_W       = 21,
   parameter int SYNC_STAGES = 2,
   parameter bit RISE_EDGE   = 1'b1,
   localparam int ACC_W      = CNT_W + $clog2(NPER),
   localparam int ERR_W      = ACC_W + 1
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic                    sig_i,
   input  logic                    start_i,
   input  logic [ACC_W-1:0]        setpoint_i,
   input  logic [TMO_W-1:0]        tmo_limit_i,
   output logic [ACC_W-1:0]        count_o,
   output logic signed [ERR_W-1:0] err_o,
   output logic                    done_o,
   output logic                    tmo_o
);
   generate
      if (NPER < 2 || (NPER & (NPER - 1)) != 0) begin : g_bad_nper
         $error("NPER must be a power of two of at least 2");
      end
      if (TMO_W > CNT_W) begin : g_bad_tmo
         $error("TMO_W must not exceed CNT_W, or the window could overflow");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   pm_state_t          state_q;
   logic [ACC_W-1:0]   sp_q;
   logic [TMO_W-1:0]   lim_q;
   logic               edge_s;
   logic               expire_s;
   logic               last_s;
   logic [ACC_W-1:0]   total_s;
   logic signed [ERR_W-1:0] diff_s;

   pm_edge_sync #(
      .STAGES   (SYNC_STAGES),
      .RISE_EDGE(RISE_EDGE)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .async_i(sig_i),
      .edge_o (edge_s)
   );

   pm_watchdog #(
      .TMO_W(TMO_W)
   ) u_wdog (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .clear_i (start_i),
      .active_i(state_q != PM_IDLE),
      .edge_i  (edge_s),
      .limit_i (lim_q),
      .expire_o(expire_s)
   );

   pm_window #(
      .ACC_W(ACC_W),
      .NPER (NPER)
   ) u_win (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .clear_i(start_i || (state_q == PM_ARM && edge_s)),
      .run_i  (state_q == PM_RUN),
      .edge_i (edge_s),
      .total_o(total_s),
      .last_o (last_s)
   );

   assign diff_s = $signed({1'b0, total_s}) - $signed({1'b0, sp_q});

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= PM_IDLE;
         sp_q    <= '0;
         lim_q   <= '0;
         count_o <= '0;
         err_o   <= '0;
         done_o  <= 1'b0;
         tmo_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            state_q <= PM_ARM;
            sp_q    <= setpoint_i;
            lim_q   <= tmo_limit_i;
            count_o <= '0;
            err_o   <= '0;
            tmo_o   <= 1'b0;
         end else begin
            case (state_q)
               PM_ARM: begin
                  if (expire_s) begin
                     tmo_o   <= 1'b1;
                     state_q <= PM_IDLE;
                  end else if (edge_s) begin
                     state_q <= PM_RUN;
                  end
               end
               PM_RUN: begin
                  if (expire_s) begin
                     tmo_o   <= 1'b1;
                     state_q <= PM_IDLE;
                  end else if (last_s) begin
                     count_o <= total_s;
                     err_o   <= diff_s;
                     done_o  <= 1'b1;
                     state_q <= PM_IDLE;
                  end
               end
               default: state_q <= PM_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/period_avg_meter_chk.sv
module period_avg_meter_chk #(
   parameter int ACC_W = 26,
   parameter int ERR_W = 27,
   parameter int NPER  = 32
) (
   input logic                    clk_i,
   input logic                    rst_i,
   input logic                    start_i,
   input logic                    done_o,
   input logic                    tmo_o,
   input logic [ACC_W-1:0]        count_o,
   input logic signed [ERR_W-1:0] err_o,
   input logic [ACC_W-1:0]        sp_q
);
   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !done_o); // R4

   AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (rst_i)
      !start_i |=> (done_o || ($stable(count_o) && $stable(err_o)))); // R5

   AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
      start_i |=> (count_o == '0 && err_o == '0 && !tmo_o && !done_o)); // R5

   AST_ERR_RELATION: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> (err_o == ($signed({1'b0, count_o}) - $signed({1'b0, sp_q})))); // R3

   AST_TMO_NO_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
      tmo_o |-> !done_o); // R7

   AST_COUNT_FLOOR: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> (count_o >= ACC_W'(NPER))); // R2
endmodule

bind period_avg_meter period_avg_meter_chk #(
   .ACC_W(ACC_W),
   .ERR_W(ERR_W),
   .NPER (NPER)
) u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .start_i(start_i),
   .done_o (done_o),
   .tmo_o  (tmo_o),
   .count_o(count_o),
   .err_o  (err_o),
   .sp_q   (sp_q)
);

// File: tb/tb_period_avg_meter.sv
module tb_period_avg_meter;
   localparam int CLK_NS = 10;
   localparam int NPER   = 32;
   localparam int CNT_W  = 21;
   localparam int TMO_W  = 21;
   localparam int ACC_W  = 26;
   localparam int ERR_W  = 27;

   logic                    clk = 1'b0;
   logic                    rst = 1'b1;
   logic                    sig = 1'b0;
   logic                    start = 1'b0;
   logic [ACC_W-1:0]        setpoint = '0;
   logic [TMO_W-1:0]        tmo_limit = '0;
   logic [ACC_W-1:0]        count_o;
   logic signed [ERR_W-1:0] err_o;
   logic                    done_o;
   logic                    tmo_o;

   int n_chk = 0;
   int n_bad = 0;
   int hi[48];
   int lo[48];

   period_avg_meter #(
      .CNT_W(CNT_W), .NPER(NPER), .TMO_W(TMO_W), .SYNC_STAGES(2), .RISE_EDGE(1'b1)
   ) dut (
      .clk_i(clk), .rst_i(rst), .sig_i(sig), .start_i(start),
      .setpoint_i(setpoint), .tmo_limit_i(tmo_limit),
      .count_o(count_o), .err_o(err_o), .done_o(done_o), .tmo_o(tmo_o)
   );

   always #(CLK_NS/2) clk = ~clk;

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint win_sum();
      longint s = 0;
      for (int k = 0; k < NPER; k++) s += hi[k] + lo[k];
      return s;
   endfunction

   function automatic longint exp_err(input longint cnt, input longint sp);
      return cnt - sp;
   endfunction

   task automatic set_const(input int h, input int l);
      for (int k = 0; k < 48; k++) begin
         hi[k] = h;
         lo[k] = l;
      end
   endtask

   task automatic pulse_start(input longint sp, input longint lim);
      @(negedge clk);
      setpoint  = ACC_W'(sp);
      tmo_limit = TMO_W'(lim);
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
   endtask

   task automatic gen(input int nper);
      for (int k = 0; k < nper; k++) begin
         sig = 1'b1;
         repeat (hi[k]) @(negedge clk);
         sig = 1'b0;
         repeat (lo[k]) @(negedge clk);
      end
   endtask

   task automatic wait_done(input int budget, output bit seen,
                            output longint c, output longint e);
      seen = 1'b0;
      c = 0;
      e = 0;
      for (int i = 0; i < budget; i++) begin
         @(negedge clk);
         if (done_o) begin
            seen = 1'b1;
            c = longint'(count_o);
            e = longint'(err_o);
            @(negedge clk);
            chk("R4 done one cycle wide", longint'(done_o), 0);
            break;
         end
      end
   endtask

   // Full measurement with extra periods after completion to probe R5.
   task automatic run_meas(input longint sp, input longint lim, input string tag);
      bit seen;
      longint c, e, expc;
      int budget;
      budget = 0;
      for (int k = 0; k < NPER + 4; k++) budget += hi[k] + lo[k];
      pulse_start(sp, lim);
      repeat (3) @(negedge clk);
      fork
         gen(NPER + 4);
         wait_done(budget + 40, seen, c, e);
      join
      expc = win_sum();
      chk({tag, " R4 done seen"}, longint'(seen), 1);
      chk({tag, " R2 count"}, c, expc);
      chk({tag, " R3 error"}, e, exp_err(expc, sp));
      chk({tag, " R5 count held after later edges"}, longint'(count_o), expc);
      chk({tag, " R5 error held after later edges"}, longint'(err_o), exp_err(expc, sp));
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit seen;
      longint c, e;
      void'($urandom(32'd20080808));

      repeat (4) @(negedge clk);
      chk("R1 count in reset", longint'(count_o), 0);
      chk("R1 done in reset", longint'(done_o), 0);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 count after reset", longint'(count_o), 0);
      chk("R1 error after reset", longint'(err_o), 0);
      chk("R1 timeout after reset", longint'(tmo_o), 0);

      // Directed: constant period, zero, negative and positive error (R3).
      set_const(7, 13);
      run_meas(640, 1000, "const-zero");
      run_meas(700, 1000, "const-neg");
      run_meas(0, 1000, "const-pos");
      run_meas(64'h3FF_FFFF, 1000, "const-maxsp");

      // Random duty and period per cycle (R8, R2).
      for (int t = 0; t < 8; t++) begin
         longint s;
         for (int k = 0; k < 48; k++) begin
            hi[k] = 2 + int'($urandom_range(38));
            lo[k] = 2 + int'($urandom_range(38));
         end
         s = win_sum();
         run_meas(longint'($urandom_range(32'(2 * s))), 2000, "R8 random duty");
      end

      // Timeout boundary (R7): gap equal to limit accepted.
      set_const(8, 12);
      run_meas(640, 20, "R7 limit equals period");

      // Gap one above limit aborts.
      pulse_start(640, 19);
      repeat (3) @(negedge clk);
      fork
         gen(NPER + 1);
         wait_done(NPER * 20 + 40, seen, c, e);
      join
      chk("R7 no done when gap exceeds limit", longint'(seen), 0);
      chk("R7 timeout flag", longint'(tmo_o), 1);
      chk("R7 count stays zero", longint'(count_o), 0);

      // Start clears the flag (R5).
      pulse_start(0, 50);
      chk("R5 start clears timeout", longint'(tmo_o), 0);
      chk("R5 start clears count", longint'(count_o), 0);
      // Silent input times out (R7).
      repeat (80) @(negedge clk);
      chk("R7 silent input times out", longint'(tmo_o), 1);
      chk("R7 silent input count", longint'(count_o), 0);

      // Restart mid-window (R6).
      set_const(5, 10);
      pulse_start(480, 1000);
      repeat (3) @(negedge clk);
      fork
         gen(45);
         begin
            repeat (100) @(negedge clk);
            pulse_start(400, 1000);
            wait_done(800, seen, c, e);
         end
      join
      chk("R6 done after restart", longint'(seen), 1);
      chk("R6 count after restart", c, 480);
      chk("R6 error uses restart setpoint", e, 80);

      // Setpoint and limit changed mid-window (R9).
      set_const(9, 11);
      pulse_start(640, 1000);
      repeat (3) @(negedge clk);
      fork
         gen(NPER + 2);
         begin
            repeat (50) @(negedge clk);
            setpoint  = ACC_W'(5);
            tmo_limit = TMO_W'(3);
            wait_done(NPER * 20 + 60, seen, c, e);
         end
      join
      chk("R9 done despite limit change", longint'(seen), 1);
      chk("R9 error uses sampled setpoint", e, 0);
      chk("R9 count", c, 640);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule